// File: doc/BRIEF.md
# Three-Channel Match-Compare Timer

The block holds three independent 32-bit up-counters. Each counter has three match comparators. Software reaches the block over a simple synchronous register bus clocked by `busClk`. The counters advance on a separate, slower `tmrClk`. Each counter picks one of four tick-enable sources in that clock domain. A counter either runs freely and wraps at 2^32, or restarts whenever it reaches the value of its first comparator. In either case it restarts from zero or, when reloading is switched on, from a programmable start value.

When a counter moves onto a comparator's value, the comparator raises a sticky status bit. Each counter has one interrupt line, which is high while any status bit is set and has its enable bit set. Software clears status bits by writing ones to them.

Software cannot read a running count directly. It writes to the counter's capture register, which sends a request into the timer domain. The block then holds a frozen snapshot of the count. A global flag tells software when that snapshot is safe to read.

Top module: `match_timer_unit`

## Requirements
- R1: After reset every counter is stopped and holds 0. Every configuration register, status bit, capture-valid flag and interrupt line reads 0.
- R2: An enabled counter i adds one on each `tmrClk` rising edge where `tmrTick[sel]` is 1. `sel` is the 2-bit field at bits [2i+1:2i] of the clock-select register, at word address 1. Ticks on the other sources are ignored.
- R3: Bit i of the enable register (word address 0) controls counter i. While the bit is 0, ticks leave the count unchanged. Setting the bit again resumes counting from the held value.
- R4: When bit i of the mode register (word address 2) is 0, the counter runs in periodic mode. A tick taken while the count equals match 0 loads the restart value instead of count+1. The restart value is the preload word if bit 0 of the reload-control register is 1, and 0 otherwise.
- R5: When the mode bit is 1, the counter runs freely. A tick taken at all-ones wraps the count to the restart value. With reload off, that value is 0.
- R6: Status bit j of counter i is set when a tick moves the count onto the value of match j. The bit stays set until it is cleared, even after the count has moved past.
- R7: Writing the status register (counter offset 6) clears each status bit whose write-data bit is 1. Writing 0x7 clears all three. A set that arrives in the same bus cycle as a clear wins.
- R8: `irq[i]` is 1 one bus cycle after (status AND interrupt-enable) of counter i becomes non-zero, and 0 one cycle after it becomes zero. The interrupt-enable register is at counter offset 5, bit j for comparator j.
- R9: Any write to the capture register (counter offset 7) clears capture-valid bit i (word address 3) in the next cycle. Valid is set again after the request has crossed both ways. Reading offset 7 then returns the count at capture time.
- R10: Once valid, the snapshot does not change until the next capture request, even while the counter keeps running.
- R11: Counter i occupies word addresses 8(i+1) to 8(i+1)+7. Offsets 0 to 2 hold match 0 to 2, offset 3 the preload word, and offset 4 the reload-control bit. Offsets 0 to 5 read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Register bus clock |
| tmrClk | input | 1 | Counting clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| tmrTick | input | 4 | Tick-enable sources, sampled on tmrClk |
| busSel | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 6 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the addressed word (combinational) |
| irq | output | 3 | One interrupt line per counter |

## Verification
The wrap from all-ones to zero is the hardest case to reach from the ports, because counting up to it would take 2^32 ticks. The bench uses periodic mode with match 0 equal to the current count and reload switched on. A single tick then loads a preload just below all-ones. The bench then switches to free-running mode and ticks across the boundary. To make counts exact despite the enable synchronizer, tick sources are gated one `tmrClk` cycle at a time, and configuration changes only while the ticks are idle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCNT = 3;
  localparam int NCMP = 3;

  typedef struct packed {
    logic                       wrEnable;
    logic                       wrClkSel;
    logic                       wrMode;
    logic [NCNT-1:0][NCMP-1:0]  wrMatch;
    logic [NCNT-1:0]            wrPreload;
    logic [NCNT-1:0]            wrReload;
    logic [NCNT-1:0]            wrIrqEn;
    logic [NCNT-1:0]            wrClear;
    logic [NCNT-1:0]            capReq;
  } strobe_t;

  localparam logic [2:0] G_ENABLE = 3'd0;
  localparam logic [2:0] G_CLKSEL = 3'd1;
  localparam logic [2:0] G_MODE   = 3'd2;
  localparam logic [2:0] G_CAPVAL = 3'd3;
  localparam logic [2:0] O_PRELD  = 3'd3;
  localparam logic [2:0] O_RELOAD = 3'd4;
  localparam logic [2:0] O_IEN    = 3'd5;
  localparam logic [2:0] O_STATUS = 3'd6;
  localparam logic [2:0] O_CAPT   = 3'd7;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strobes
);
  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] blockIdx;
  logic [2:0]       offset;
  logic             wrAccess;

  assign blockIdx = busAddr[ADDR_W-1:3];
  assign offset   = busAddr[2:0];
  assign wrAccess = busSel && busWrite;

  always_comb begin
    strobes = '0;
    if (wrAccess) begin
      if (blockIdx == '0) begin
        strobes.wrEnable = (offset == G_ENABLE);
        strobes.wrClkSel = (offset == G_CLKSEL);
        strobes.wrMode   = (offset == G_MODE);
      end
      for (int i = 0; i < NCNT; i++) begin
        if (blockIdx == IDX_W'(i + 1)) begin
          for (int j = 0; j < NCMP; j++)
            strobes.wrMatch[i][j] = (offset == 3'(j));
          strobes.wrPreload[i] = (offset == O_PRELD);
          strobes.wrReload[i]  = (offset == O_RELOAD);
          strobes.wrIrqEn[i]   = (offset == O_IEN);
          strobes.wrClear[i]   = (offset == O_STATUS);
          strobes.capReq[i]    = (offset == O_CAPT);
        end
      end
    end
  end
endmodule

// File: rtl/tmr_slice.sv
module tmr_slice #(
  parameter int CNT_W = 32,
  parameter int NCMP  = 3
) (
  input  logic                       tmrClk,
  input  logic                       rstN,
  input  logic                       enAsync,
  input  logic                       freeRun,
  input  logic                       reloadOn,
  input  logic                       tick,
  input  logic                       capReqTgl,
  input  logic [CNT_W-1:0]           preload,
  input  logic [NCMP-1:0][CNT_W-1:0] matchVal,
  output logic                       capAckTgl,
  output logic [CNT_W-1:0]           snapshot,
  output logic [NCMP-1:0]            hitTgl
);
  logic [1:0]       enSync;
  logic [1:0]       reqSync;
  logic             reqPrev;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] nextCount;
  logic             advance;
  logic             atWrap;

  assign advance   = enSync[1] && tick;
  assign atWrap    = freeRun ? (count == '1) : (count == matchVal[0]);
  assign nextCount = atWrap ? (reloadOn ? preload : '0) : count + CNT_W'(1);

  always_ff @(posedge tmrClk or negedge rstN) begin
    if (!rstN) begin
      enSync    <= '0;
      reqSync   <= '0;
      reqPrev   <= 1'b0;
      count     <= '0;
      snapshot  <= '0;
      capAckTgl <= 1'b0;
    end else begin
      enSync  <= {enSync[0], enAsync};
      reqSync <= {reqSync[0], capReqTgl};
      reqPrev <= reqSync[1];
      if (advance) count <= nextCount;
      if (reqSync[1] != reqPrev) begin
        snapshot  <= count;
        capAckTgl <= ~capAckTgl;
      end
    end
  end

  for (genvar j = 0; j < NCMP; j++) begin : g_hit
    always_ff @(posedge tmrClk or negedge rstN) begin
      if (!rstN)                                  hitTgl[j] <= 1'b0;
      else if (advance && nextCount == matchVal[j]) hitTgl[j] <= ~hitTgl[j];
    end
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6,
  parameter int NSRC   = 4
) (
  input  logic                                  busClk,
  input  logic                                  tmrClk,
  input  logic                                  rstN,
  input  strobe_t                               strobes,
  input  logic [CNT_W-1:0]                      wdata,
  input  logic [ADDR_W-1:0]                     busAddr,
  input  logic [NSRC-1:0]                       tmrTick,
  output logic [CNT_W-1:0]                      rdata,
  output logic [NCNT-1:0]                       irq,
  output logic [NCNT-1:0]                       capValid,
  output logic [NCNT-1:0][NCMP-1:0]             status,
  output logic [NCNT-1:0][NCMP-1:0]             setPulse,
  output logic [NCNT-1:0][NCMP-1:0]             irqEn,
  output logic [NCNT-1:0][CNT_W-1:0]            snapshot
);
  localparam int SEL_W = $clog2(NSRC);
  localparam int IDX_W = ADDR_W - 3;

  logic [NCNT-1:0]                       enableReg;
  logic [NCNT-1:0]                       modeReg;
  logic [NCNT-1:0][SEL_W-1:0]            clkSelReg;
  logic [NCNT-1:0]                       reloadReg;
  logic [NCNT-1:0][CNT_W-1:0]            preloadReg;
  logic [NCNT-1:0][NCMP-1:0][CNT_W-1:0]  matchReg;
  logic [NCNT-1:0]                       capReqTgl;
  logic [NCNT-1:0]                       capAckTgl;

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      enableReg <= '0;
      modeReg   <= '0;
      clkSelReg <= '0;
    end else begin
      if (strobes.wrEnable) enableReg <= wdata[NCNT-1:0];
      if (strobes.wrMode)   modeReg   <= wdata[NCNT-1:0];
      if (strobes.wrClkSel) clkSelReg <= wdata[NCNT*SEL_W-1:0];
    end
  end

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    logic [NCMP-1:0] hitTgl;
    logic [NCMP-1:0] hitS1, hitS2, hitPrev;
    logic [1:0]      ackSync;
    logic            ackPrev;
    logic [NCMP-1:0] clrMask;

    assign setPulse[i] = hitS2 ^ hitPrev;
    assign clrMask     = strobes.wrClear[i] ? wdata[NCMP-1:0] : '0;

    always_ff @(posedge busClk or negedge rstN) begin
      if (!rstN) begin
        matchReg[i]   <= '0;
        preloadReg[i] <= '0;
        reloadReg[i]  <= 1'b0;
        irqEn[i]      <= '0;
        status[i]     <= '0;
        irq[i]        <= 1'b0;
        hitS1         <= '0;
        hitS2         <= '0;
        hitPrev       <= '0;
        ackSync       <= '0;
        ackPrev       <= 1'b0;
        capReqTgl[i]  <= 1'b0;
        capValid[i]   <= 1'b0;
      end else begin
        for (int j = 0; j < NCMP; j++)
          if (strobes.wrMatch[i][j]) matchReg[i][j] <= wdata;
        if (strobes.wrPreload[i]) preloadReg[i] <= wdata;
        if (strobes.wrReload[i])  reloadReg[i]  <= wdata[0];
        if (strobes.wrIrqEn[i])   irqEn[i]      <= wdata[NCMP-1:0];
        hitS1     <= hitTgl;
        hitS2     <= hitS1;
        hitPrev   <= hitS2;
        status[i] <= (status[i] & ~clrMask) | setPulse[i];
        irq[i]    <= |(status[i] & irqEn[i]);
        ackSync   <= {ackSync[0], capAckTgl[i]};
        ackPrev   <= ackSync[1];
        if (strobes.capReq[i]) begin
          capReqTgl[i] <= ~capReqTgl[i];
          capValid[i]  <= 1'b0;
        end else if (ackSync[1] != ackPrev) begin
          capValid[i]  <= 1'b1;
        end
      end
    end

    tmr_slice #(.CNT_W(CNT_W), .NCMP(NCMP)) i_slice (
      .tmrClk    (tmrClk),
      .rstN      (rstN),
      .enAsync   (enableReg[i]),
      .freeRun   (modeReg[i]),
      .reloadOn  (reloadReg[i]),
      .tick      (tmrTick[clkSelReg[i]]),
      .capReqTgl (capReqTgl[i]),
      .preload   (preloadReg[i]),
      .matchVal  (matchReg[i]),
      .capAckTgl (capAckTgl[i]),
      .snapshot  (snapshot[i]),
      .hitTgl    (hitTgl)
    );
  end

  always_comb begin
    rdata = '0;
    if (busAddr[ADDR_W-1:3] == '0) begin
      case (busAddr[2:0])
        G_ENABLE: rdata = CNT_W'(enableReg);
        G_CLKSEL: rdata = CNT_W'(clkSelReg);
        G_MODE:   rdata = CNT_W'(modeReg);
        G_CAPVAL: rdata = CNT_W'(capValid);
        default:  rdata = '0;
      endcase
    end
    for (int i = 0; i < NCNT; i++) begin
      if (busAddr[ADDR_W-1:3] == IDX_W'(i + 1)) begin
        for (int j = 0; j < NCMP; j++)
          if (busAddr[2:0] == 3'(j)) rdata = matchReg[i][j];
        case (busAddr[2:0])
          O_PRELD:  rdata = preloadReg[i];
          O_RELOAD: rdata = CNT_W'(reloadReg[i]);
          O_IEN:    rdata = CNT_W'(irqEn[i]);
          O_STATUS: rdata = CNT_W'(status[i]);
          O_CAPT:   rdata = snapshot[i];
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/match_timer_unit.sv
module match_timer_unit
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6,
  parameter int NSRC   = 4
) (
  input  logic              busClk,
  input  logic              tmrClk,
  input  logic              rstN,
  input  logic [NSRC-1:0]   tmrTick,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  output logic [NCNT-1:0]   irq
);
  strobe_t                       strobes;
  logic [NCNT-1:0]               capValid;
  logic [NCNT-1:0][NCMP-1:0]     status;
  logic [NCNT-1:0][NCMP-1:0]     setPulse;
  logic [NCNT-1:0][NCMP-1:0]     irqEn;
  logic [NCNT-1:0][CNT_W-1:0]    snapshot;

  tmr_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobes  (strobes)
  );

  tmr_datapath #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .NSRC(NSRC)) i_dp (
    .busClk   (busClk),
    .tmrClk   (tmrClk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wdata    (busWdata),
    .busAddr  (busAddr),
    .tmrTick  (tmrTick),
    .rdata    (busRdata),
    .irq      (irq),
    .capValid (capValid),
    .status   (status),
    .setPulse (setPulse),
    .irqEn    (irqEn),
    .snapshot (snapshot)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                        busClk,
  input logic                        rstN,
  input strobe_t                     strobes,
  input logic [CNT_W-1:0]            wdata,
  input logic [NCNT-1:0][NCMP-1:0]   status,
  input logic [NCNT-1:0][NCMP-1:0]   setPulse,
  input logic [NCNT-1:0][NCMP-1:0]   irqEn,
  input logic [NCNT-1:0]             irq,
  input logic [NCNT-1:0]             capValid,
  input logic [NCNT-1:0][CNT_W-1:0]  snapshot
);
  for (genvar i = 0; i < NCNT; i++) begin : g_c
    for (genvar j = 0; j < NCMP; j++) begin : g_m
      p_sticky_r6: assert property (@(posedge busClk) disable iff (!rstN)
        (status[i][j] && !(strobes.wrClear[i] && wdata[j])) |=> status[i][j]);
      p_set_wins_r7: assert property (@(posedge busClk) disable iff (!rstN)
        setPulse[i][j] |=> status[i][j]);
      p_clear_r7: assert property (@(posedge busClk) disable iff (!rstN)
        (strobes.wrClear[i] && wdata[j] && !setPulse[i][j]) |=> !status[i][j]);
    end
    p_irq_high_r8: assert property (@(posedge busClk) disable iff (!rstN)
      (|(status[i] & irqEn[i])) |=> irq[i]);
    p_irq_low_r8: assert property (@(posedge busClk) disable iff (!rstN)
      !(|(status[i] & irqEn[i])) |=> !irq[i]);
    p_cap_drop_r9: assert property (@(posedge busClk) disable iff (!rstN)
      strobes.capReq[i] |=> !capValid[i]);
    p_snap_stable_r10: assert property (@(posedge busClk) disable iff (!rstN)
      (capValid[i] && $past(capValid[i])) |-> $stable(snapshot[i]));
  end
endmodule

bind match_timer_unit tmr_checker #(.CNT_W(CNT_W)) i_checker (
  .busClk   (busClk),
  .rstN     (rstN),
  .strobes  (strobes),
  .wdata    (busWdata),
  .status   (status),
  .setPulse (setPulse),
  .irqEn    (irqEn),
  .irq      (irq),
  .capValid (capValid),
  .snapshot (snapshot)
);

// File: tb/test_match_timer_unit.sv
module test_match_timer_unit;
  logic        busClk = 1'b0;
  logic        tmrClk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  tmrTick = '0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [2:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 busClk = ~busClk;
  initial begin
    #3;
    forever #15 tmrClk = ~tmrClk;
  end

  match_timer_unit i_match_timer_unit (
    .busClk(busClk), .tmrClk(tmrClk), .rstN(rstN), .tmrTick(tmrTick),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [5:0] a, input logic [31:0] d);
    @(negedge busClk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge busClk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [5:0] a, output logic [31:0] d);
    @(negedge busClk);
    busAddr = a; busSel = 1'b1; busWrite = 1'b0;
    #2 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic waitBus(input int n);
    repeat (n) @(negedge busClk);
  endtask

  task automatic waitTmr(input int n);
    repeat (n) @(negedge tmrClk);
  endtask

  task automatic pulseTicks(input int src, input int n);
    if (n > 0) begin
      @(negedge tmrClk);
      tmrTick[src] = 1'b1;
      repeat (n) @(negedge tmrClk);
      tmrTick[src] = 1'b0;
    end
    waitBus(12);
  endtask

  function automatic logic [5:0] cAddr(input int i, input int off);
    return 6'(8 * (i + 1) + off);
  endfunction

  task automatic capture(input int i, output logic [31:0] v);
    logic [31:0] f;
    busWr(cAddr(i, 7), 32'h0);
    f = '0;
    for (int k = 0; k < 200 && !f[i]; k++) busRd(6'd3, f);
    busRd(cAddr(i, 7), v);
  endtask

  task automatic doReset;
    rstN = 1'b0;
    tmrTick = '0;
    waitBus(4);
    rstN = 1'b1;
    waitBus(2);
  endtask

  task automatic enableOnly(input logic [2:0] m);
    busWr(6'd0, 32'(m));
    waitTmr(4);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2, sum;
    doReset();

    // R1: reset state of global and per-counter registers
    busRd(6'd0, v); chk("R1 enable", v, 0);
    busRd(6'd1, v); chk("R1 clksel", v, 0);
    busRd(6'd2, v); chk("R1 mode", v, 0);
    busRd(6'd3, v); chk("R1 capvalid", v, 0);
    for (int i = 0; i < 3; i++) begin
      busRd(cAddr(i, 6), v); chk("R1 status", v, 0);
      busRd(cAddr(i, 0), v); chk("R1 match", v, 0);
    end
    chk("R1 irq", 32'(irq), 0);
    capture(0, v); chk("R1 count", v, 0);

    // R11: readback of per-counter registers
    for (int i = 0; i < 3; i++) begin
      for (int off = 0; off < 4; off++) begin
        busWr(cAddr(i, off), 32'h1000_0000 * (i + 1) + 32'(off * 7 + 3));
        busRd(cAddr(i, off), v);
        chk("R11 readback", v, 32'h1000_0000 * (i + 1) + 32'(off * 7 + 3));
      end
      busWr(cAddr(i, 4), 32'h1); busRd(cAddr(i, 4), v); chk("R11 reload", v, 1);
      busWr(cAddr(i, 5), 32'h5); busRd(cAddr(i, 5), v); chk("R11 ien", v, 5);
    end

    // R2: tick sweep on counter 0, free-running, source 0
    doReset();
    busWr(6'd2, 32'h7);
    for (int j = 0; j < 3; j++) busWr(cAddr(0, j), 32'hFFFF_0000);
    enableOnly(3'b001);
    sum = 0;
    for (int n = 1; n <= 10; n++) begin
      pulseTicks(0, n);
      sum += 32'(n);
      capture(0, v);
      chk("R2 sweep count", v, sum);
    end

    // R2: clock select field for counter 1 = source 2
    doReset();
    busWr(6'd2, 32'h7);
    for (int j = 0; j < 3; j++) busWr(cAddr(1, j), 32'hFFFF_0000);
    busWr(6'd1, 32'h8);
    enableOnly(3'b010);
    pulseTicks(0, 5);
    capture(1, v); chk("R2 other source ignored", v, 0);
    pulseTicks(2, 7);
    capture(1, v); chk("R2 selected source", v, 7);

    // R3: enable halts and resumes counter 2
    doReset();
    busWr(6'd2, 32'h7);
    for (int j = 0; j < 3; j++) busWr(cAddr(2, j), 32'hFFFF_0000);
    enableOnly(3'b100);
    pulseTicks(0, 5);
    enableOnly(3'b000);
    pulseTicks(0, 6);
    capture(2, v); chk("R3 halted", v, 5);
    enableOnly(3'b100);
    pulseTicks(0, 3);
    capture(2, v); chk("R3 resumed", v, 8);

    // R4: periodic restart at match 0, reload off then on
    doReset();
    busWr(cAddr(0, 0), 32'd4);
    busWr(cAddr(0, 1), 32'd100);
    busWr(cAddr(0, 2), 32'd100);
    enableOnly(3'b001);
    pulseTicks(0, 7);
    capture(0, v); chk("R4 restart to zero", v, 2);
    doReset();
    busWr(cAddr(0, 0), 32'd4);
    busWr(cAddr(0, 1), 32'd100);
    busWr(cAddr(0, 2), 32'd100);
    busWr(cAddr(0, 3), 32'd10);
    busWr(cAddr(0, 4), 32'd1);
    enableOnly(3'b001);
    pulseTicks(0, 7);
    capture(0, v); chk("R4 restart to preload", v, 12);

    // R5: free-running wrap across all-ones
    doReset();
    busWr(cAddr(0, 3), 32'hFFFF_FFFD);
    busWr(cAddr(0, 4), 32'd1);
    busWr(cAddr(0, 1), 32'd50);
    busWr(cAddr(0, 2), 32'd50);
    enableOnly(3'b001);
    pulseTicks(0, 1);
    capture(0, v); chk("R4 preload near top", v, 32'hFFFF_FFFD);
    busWr(6'd2, 32'h1);
    busWr(cAddr(0, 4), 32'd0);
    waitTmr(4);
    pulseTicks(0, 2);
    capture(0, v); chk("R5 at all-ones", v, 32'hFFFF_FFFF);
    pulseTicks(0, 2);
    capture(0, v); chk("R5 wrapped", v, 1);

    // R6/R7/R8: status, clear, interrupt on counter 1
    doReset();
    busWr(6'd2, 32'h7);
    busWr(cAddr(1, 0), 32'd2);
    busWr(cAddr(1, 1), 32'd4);
    busWr(cAddr(1, 2), 32'd6);
    enableOnly(3'b010);
    pulseTicks(0, 4);
    busRd(cAddr(1, 6), v); chk("R6 two matches", v, 3);
    chk("R8 irq masked", 32'(irq), 0);
    busWr(cAddr(1, 5), 32'h2);
    waitBus(2);
    chk("R8 irq raised", 32'(irq), 32'h2);
    busWr(cAddr(1, 6), 32'h1);
    busRd(cAddr(1, 6), v); chk("R7 clear one bit", v, 2);
    chk("R8 irq still high", 32'(irq), 32'h2);
    busWr(cAddr(1, 6), 32'h2);
    busRd(cAddr(1, 6), v); chk("R7 clear other bit", v, 0);
    waitBus(2);
    chk("R8 irq dropped", 32'(irq), 0);
    pulseTicks(0, 2);
    busRd(cAddr(1, 6), v); chk("R6 third match", v, 4);
    pulseTicks(0, 3);
    busRd(cAddr(1, 6), v); chk("R6 sticky after passing", v, 4);
    waitBus(2);
    chk("R8 wrong enable", 32'(irq), 0);
    busWr(cAddr(1, 5), 32'h4);
    waitBus(2);
    chk("R8 irq via match 2", 32'(irq), 32'h2);
    busWr(cAddr(1, 6), 32'h7);
    busRd(cAddr(1, 6), v); chk("R7 clear all", v, 0);

    // R9/R10: capture valid flag and snapshot stability
    doReset();
    busWr(6'd2, 32'h7);
    for (int j = 0; j < 3; j++) busWr(cAddr(2, j), 32'hFFFF_0000);
    enableOnly(3'b100);
    pulseTicks(0, 9);
    capture(2, v); chk("R9 captured", v, 9);
    pulseTicks(0, 4);
    busRd(cAddr(2, 7), v2); chk("R10 snapshot held", v2, 9);
    busRd(6'd3, v2); chk("R10 valid held", v2 & 32'h4, 32'h4);
    busWr(cAddr(2, 7), 32'h0);
    busRd(6'd3, v2); chk("R9 valid cleared", v2 & 32'h4, 0);
    waitBus(40);
    busRd(6'd3, v2); chk("R9 valid returns", v2 & 32'h4, 32'h4);
    busRd(cAddr(2, 7), v2); chk("R9 new snapshot", v2, 13);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule